// File: doc/BRIEF.md
# Dual-Channel Regulator Start-up Sequencer

This block is the digital controller of a two-output linear regulator. It watches two channel enable requests and a supply-good comparator. It powers the shared analog support stages one after another, and each stage must report ready before the next one starts. The order is: trim capture, bandgap, reference and bias, then bypass fast charge. After that it releases the two output channels. The analog loop, the ramp shaping and the current limit sit outside the block. They appear here only as ready and in-regulation flags.

Channel 1 takes priority whenever its request is pending before channel 2 has begun to ramp. Channel 2 is then held until channel 1 is in regulation. If channel 2 is already ramping when channel 1 is requested, channel 1 starts at once and both ramp together. A loss of supply drops everything at once, and the sequence restarts by itself when the supply returns. A stage or channel that never reports ready sets a fault and returns the block to shutdown.

Top module: `dual_rail_seq`

## Requirements
- R1: While both synchronized enables are low, every stage control, every channel enable and every start strobe is 0 from the next clock on.
- R2: Enables and supply-good each pass through a two-flop synchronizer. With supply-good already high and the block idle, `trim_load_o` is 0 after the third rising edge that follows an enable rising, and 1 after the fourth.
- R3: While synchronized supply-good is low, the sequence does not start and no stage control rises.
- R4: The stages run in this order: trim (`trim_load_o`), bandgap (`bgap_on_o`), reference (`vref_on_o`), bypass charge (`byp_fast_o`). Each stage advances one cycle after its ready input is seen. `bgap_on_o` and `vref_on_o` stay high until shutdown. `trim_load_o` and `byp_fast_o` are high only in their own step. Channels may start only after the bypass step.
- R5: If both enables arrive together, channel 1 (bit 0) starts first and channel 2 (bit 1) stays off until channel 1 reports in regulation.
- R6: If channel 2 is requested while channel 1 is ramping, channel 2 starts on the second edge after channel 1's in-regulation flag is seen high.
- R7: If channel 2 is requested first and channel 1 is requested before channel 2 has begun ramping, channel 1 ramps first.
- R8: If channel 1 is requested while channel 2 is ramping, channel 1 starts on the third edge after its enable rises, and channel 2 keeps running.
- R9: One cycle after synchronized supply-good falls in any active state, all stage controls and channels drop and no start strobe fires. When supply-good returns, the sequence reruns on its own.
- R10: If a stage ready flag or a channel in-regulation flag is not seen within `TMO_CYCLES` cycles, `fault_o` rises and every output drops. The fault holds, with no restart, until both enables are low.
- R11: Removing one enable turns off that channel only. Bandgap and reference stay on while the other enable is high.
- R12: `ch_start_o[i]` is a single-cycle strobe. It fires on the same edge that `ch_on_o[i]` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en_i | input | 2 | Channel enable requests (bit 0 = channel 1), asynchronous |
| supply_ok_i | input | 1 | Undervoltage comparator, 1 = supply above threshold, asynchronous |
| trim_done_i | input | 1 | Trim captured |
| bg_ready_i | input | 1 | Bandgap settled |
| ref_ready_i | input | 1 | Reference and bias settled |
| byp_ready_i | input | 1 | Bypass capacitor charged |
| ch_reg_i | input | 2 | Per-channel output in regulation |
| trim_load_o | output | 1 | Capture trim settings |
| bgap_on_o | output | 1 | Bandgap power |
| vref_on_o | output | 1 | Reference and current generator power |
| byp_fast_o | output | 1 | Bypass fast-charge enable |
| ch_on_o | output | 2 | Per-channel regulator enable |
| ch_start_o | output | 2 | Per-channel ramp-start strobe |
| fault_o | output | 1 | Ready timeout occurred |

## Verification
The contested cycle is the one in which channel 2 is released, because channel 1 has just reached regulation, and the synchronized supply-good falls in that same cycle. The bench holds channel 1 ramping with channel 2 waiting. It drops supply-good one cycle before it raises channel 1's in-regulation flag, so that the release and the supply loss meet on the same edge. The supply loss must win: no start strobe for channel 2, and every output off one edge later. After supply-good returns, channel 1 must again come up first.

// File: rtl/drs_pkg.sv
package drs_pkg;

  localparam int NUM_STAGES = 4;

  typedef enum logic [2:0] {
    S_OFF, S_WAIT, S_TRIM, S_BG, S_REF, S_BYP, S_RUN
  } seq_state_t;

  typedef enum logic [1:0] {
    C_IDLE, C_RAMP, C_UP
  } chan_state_t;

  typedef struct packed {
    logic trim;
    logic bg;
    logic refg;
    logic byp;
  } stage_drive_t;

  function automatic logic is_stage(seq_state_t s);
    return (s == S_TRIM) || (s == S_BG) || (s == S_REF) || (s == S_BYP);
  endfunction

  function automatic logic is_active(seq_state_t s);
    return is_stage(s) || (s == S_RUN);
  endfunction

  // Index of the ready flag that the current stage waits on.
  function automatic logic [1:0] stage_idx(seq_state_t s);
    case (s)
      S_BG:    return 2'd1;
      S_REF:   return 2'd2;
      S_BYP:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic stage_drive_t drive_of(seq_state_t s);
    stage_drive_t d;
    d.trim = (s == S_TRIM);
    d.bg   = (s == S_BG) || (s == S_REF) || (s == S_BYP) || (s == S_RUN);
    d.refg = (s == S_REF) || (s == S_BYP) || (s == S_RUN);
    d.byp  = (s == S_BYP);
    return d;
  endfunction

  // Channel 2 may begin only when channel 1 has no claim outstanding.
  function automatic logic ch2_clear(logic en1, chan_state_t c1);
    return !en1 || (c1 == C_UP);
  endfunction

endpackage

// File: rtl/drs_sync.sv
module drs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/drs_timer.sv
module drs_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run_i)       cnt <= '0;
    else if (cnt != LAST)  cnt <= cnt + CW'(1);
  end

  assign expired_o = run_i && (cnt == LAST);
endmodule

// File: rtl/drs_seq_fsm.sv
module drs_seq_fsm
  import drs_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_any_i,
  input  logic                  uv_i,
  input  logic [NUM_STAGES-1:0] rdy_i,
  input  logic                  tmo_i,
  output seq_state_t            state_o,
  output logic                  fault_o,
  output logic                  wait_o,
  output logic                  active_o
);
  seq_state_t st, nx;
  logic flt, flt_nx;
  logic cur_rdy;

  assign cur_rdy  = rdy_i[stage_idx(st)];
  assign wait_o   = is_stage(st) && !cur_rdy;
  assign active_o = is_active(st);

  always_comb begin
    nx     = st;
    flt_nx = flt;
    if (!en_any_i) begin
      nx     = S_OFF;
      flt_nx = 1'b0;
    end else if (flt) begin
      nx = S_OFF;
    end else if (tmo_i) begin
      nx     = S_OFF;
      flt_nx = 1'b1;
    end else if (is_active(st) && !uv_i) begin
      nx = S_WAIT;
    end else begin
      case (st)
        S_OFF:   nx = S_WAIT;
        S_WAIT:  if (uv_i)    nx = S_TRIM;
        S_TRIM:  if (cur_rdy) nx = S_BG;
        S_BG:    if (cur_rdy) nx = S_REF;
        S_REF:   if (cur_rdy) nx = S_BYP;
        S_BYP:   if (cur_rdy) nx = S_RUN;
        S_RUN:   nx = S_RUN;
        default: nx = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      flt <= 1'b0;
    end else begin
      st  <= nx;
      flt <= flt_nx;
    end
  end

  assign state_o = st;
  assign fault_o = flt;
endmodule

// File: rtl/drs_chan_arb.sv
module drs_chan_arb
  import drs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic [1:0] en_i,
  input  logic [1:0] reg_i,
  output logic [1:0] on_o,
  output logic [1:0] ramp_o,
  output logic [1:0] up_o,
  output logic [1:0] start_o
);
  localparam int NCH = 2;

  chan_state_t st [NCH];
  logic [NCH-1:0] go;

  always_comb begin
    go[0] = run_i && en_i[0] && (st[0] == C_IDLE);
    go[1] = run_i && en_i[1] && (st[1] == C_IDLE) && ch2_clear(en_i[0], st[0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) st[c] <= C_IDLE;
      start_o <= '0;
    end else begin
      start_o <= go;
      for (int c = 0; c < NCH; c++) begin
        if (!run_i || !en_i[c])                st[c] <= C_IDLE;
        else if (st[c] == C_IDLE && go[c])     st[c] <= C_RAMP;
        else if (st[c] == C_RAMP && reg_i[c])  st[c] <= C_UP;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    assign on_o[c]   = (st[c] != C_IDLE);
    assign ramp_o[c] = (st[c] == C_RAMP);
    assign up_o[c]   = (st[c] == C_UP);
  end
endmodule

// File: rtl/dual_rail_seq.sv
module dual_rail_seq
  import drs_pkg::*;
#(
  parameter int TMO_CYCLES  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ch_en_i,
  input  logic       supply_ok_i,
  input  logic       trim_done_i,
  input  logic       bg_ready_i,
  input  logic       ref_ready_i,
  input  logic       byp_ready_i,
  input  logic [1:0] ch_reg_i,
  output logic       trim_load_o,
  output logic       bgap_on_o,
  output logic       vref_on_o,
  output logic       byp_fast_o,
  output logic [1:0] ch_on_o,
  output logic [1:0] ch_start_o,
  output logic       fault_o
);
  localparam int NCH   = 2;
  localparam int NSYNC = NCH + 1;
  localparam int NTMR  = NCH + 1;

  // Synchronized inputs
  logic [NSYNC-1:0] raw_in, synced;
  logic [NCH-1:0]   en_s;
  logic             uv_s, en_any;

  assign raw_in = {supply_ok_i, ch_en_i};

  drs_sync #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (raw_in),
    .q_o   (synced)
  );

  assign en_s   = synced[NCH-1:0];
  assign uv_s   = synced[NCH];
  assign en_any = |en_s;

  // Named internal events
  seq_state_t     state;
  logic           stage_wait, seq_active, tmo_any, arb_run, fault;
  logic [NCH-1:0] ch_ramp, ch_up, ch_on, ch_start;
  logic [NTMR-1:0] tmr_run, tmr_exp;
  logic [NUM_STAGES-1:0] rdy_vec;

  assign rdy_vec = {byp_ready_i, ref_ready_i, bg_ready_i, trim_done_i};

  // Timer 0 guards the stage waits, timers 1..NCH guard the channel ramps.
  assign tmr_run = {ch_ramp, stage_wait};

  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    drs_timer #(.LIMIT(TMO_CYCLES)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .run_i     (tmr_run[t]),
      .expired_o (tmr_exp[t])
    );
  end

  assign tmo_any = |tmr_exp;

  drs_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_any_i (en_any),
    .uv_i     (uv_s),
    .rdy_i    (rdy_vec),
    .tmo_i    (tmo_any),
    .state_o  (state),
    .fault_o  (fault),
    .wait_o   (stage_wait),
    .active_o (seq_active)
  );

  assign arb_run = (state == S_RUN) && uv_s && !tmo_any;

  drs_chan_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (arb_run),
    .en_i    (en_s),
    .reg_i   (ch_reg_i),
    .on_o    (ch_on),
    .ramp_o  (ch_ramp),
    .up_o    (ch_up),
    .start_o (ch_start)
  );

  stage_drive_t drv;
  assign drv = drive_of(state);

  assign trim_load_o = drv.trim;
  assign bgap_on_o   = drv.bg;
  assign vref_on_o   = drv.refg;
  assign byp_fast_o  = drv.byp;
  assign ch_on_o     = ch_on;
  assign ch_start_o  = ch_start;
  assign fault_o     = fault;
endmodule

// File: rtl/drs_checker.sv
module drs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] en_s,
  input logic       uv_s,
  input logic       seq_active,
  input logic       arb_run,
  input logic       tmo_any,
  input logic [1:0] ch_up,
  input logic       trim_load_o,
  input logic       bgap_on_o,
  input logic       vref_on_o,
  input logic       byp_fast_o,
  input logic [1:0] ch_on_o,
  input logic [1:0] ch_start_o,
  input logic       fault_o
);
  a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s == 2'b00) |=> (!trim_load_o && !bgap_on_o && !vref_on_o && !byp_fast_o
                          && ch_on_o == 2'b00 && ch_start_o == 2'b00));

  a_r3_no_start_without_supply: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_s |=> !trim_load_o);

  a_r4_bgap_after_trim: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bgap_on_o) |-> $past(trim_load_o));

  a_r4_bypass_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    byp_fast_o |-> (vref_on_o && bgap_on_o));

  a_r5_ch2_yields: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start_o[1] |-> (!ch_start_o[0] && !(ch_on_o[0] && !ch_up[0])));

  a_r8_ch1_never_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_run && en_s[0] && !ch_on_o[0]) |=> ch_start_o[0]);

  a_r9_supply_loss_drops_all: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && !uv_s) |=> (!bgap_on_o && !vref_on_o && !byp_fast_o
                                && !trim_load_o && ch_on_o == 2'b00));

  a_r10_timeout_sets_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_any && en_s != 2'b00) |=> fault_o);

  a_r10_fault_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!trim_load_o && !bgap_on_o && ch_on_o == 2'b00));

  a_r11_ch1_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s[0] |=> !ch_on_o[0]);

  a_r11_ch2_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s[1] |=> !ch_on_o[1]);

  a_r12_strobe_ch1: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start_o[0] |=> !ch_start_o[0]);

  a_r12_strobe_ch2: assert property (@(posedge clk) disable iff (!rst_n)
    ch_start_o[1] |=> !ch_start_o[1]);
endmodule

bind dual_rail_seq drs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_s        (en_s),
  .uv_s        (uv_s),
  .seq_active  (seq_active),
  .arb_run     (arb_run),
  .tmo_any     (tmo_any),
  .ch_up       (ch_up),
  .trim_load_o (trim_load_o),
  .bgap_on_o   (bgap_on_o),
  .vref_on_o   (vref_on_o),
  .byp_fast_o  (byp_fast_o),
  .ch_on_o     (ch_on_o),
  .ch_start_o  (ch_start_o),
  .fault_o     (fault_o)
);

// File: tb/dual_rail_seq_tb.sv
module dual_rail_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n;
  logic [1:0] ch_en;
  logic       sup_ok;
  logic [3:0] auto_rdy;
  logic [1:0] reg_ok;

  logic       trim_load, bgap_on, vref_on, byp_fast, fault;
  logic [1:0] ch_on, ch_start;
  logic       trim_done, bg_ready, ref_ready, byp_ready;
  logic [1:0] ch_reg;

  // Analog models: a stage reports ready while it is powered and enabled here.
  assign trim_done = trim_load & auto_rdy[0];
  assign bg_ready  = bgap_on   & auto_rdy[1];
  assign ref_ready = vref_on   & auto_rdy[2];
  assign byp_ready = byp_fast  & auto_rdy[3];
  assign ch_reg    = reg_ok & ch_on;

  dual_rail_seq u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_en_i     (ch_en),
    .supply_ok_i (sup_ok),
    .trim_done_i (trim_done),
    .bg_ready_i  (bg_ready),
    .ref_ready_i (ref_ready),
    .byp_ready_i (byp_ready),
    .ch_reg_i    (ch_reg),
    .trim_load_o (trim_load),
    .bgap_on_o   (bgap_on),
    .vref_on_o   (vref_on),
    .byp_fast_o  (byp_fast),
    .ch_on_o     (ch_on),
    .ch_start_o  (ch_start),
    .fault_o     (fault)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int stages();
    return {28'd0, trim_load, bgap_on, vref_on, byp_fast};
  endfunction

  task automatic go_idle();
    ch_en    = 2'b00;
    reg_ok   = 2'b00;
    auto_rdy = 4'hF;
    sup_ok   = 1'b1;
    step(6);
  endtask

  task automatic wait_any_on(input int lim);
    for (int k = 0; k < lim && ch_on == 2'b00; k++) step(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ch_en = 2'b00; sup_ok = 1'b1; auto_rdy = 4'hF; reg_ok = 2'b00;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(stages() == 0, "R1 reset stages", stages(), 0);
    chk(ch_on == 2'b00 && ch_start == 2'b00, "R1 reset channels", ch_on, 0);
    chk(fault == 1'b0, "R10 reset fault", fault, 0);
  endtask

  // Latency, stage order, strobe, channel 2 waiting, per-channel disable.
  task automatic t_sequence();
    go_idle();
    ch_en = 2'b01;
    step(3);
    chk(trim_load == 1'b0, "R2 trim before 4th edge", trim_load, 0);
    step(1);
    chk(stages() == 8, "R2 trim on 4th edge", stages(), 8);
    step(1);
    chk(stages() == 4, "R4 bandgap step", stages(), 4);
    step(1);
    chk(stages() == 6, "R4 reference step", stages(), 6);
    step(1);
    chk(stages() == 7 && ch_on == 2'b00, "R4 bypass step", stages(), 7);
    step(1);
    chk(stages() == 6 && ch_on == 2'b00, "R4 run stages", stages(), 6);
    step(1);
    chk(ch_on == 2'b01 && ch_start == 2'b01, "R12 ch1 start strobe", {ch_on, ch_start}, 5);
    step(1);
    chk(ch_start == 2'b00 && ch_on == 2'b01, "R12 strobe single cycle", ch_start, 0);
    ch_en = 2'b11;
    step(8);
    chk(ch_on == 2'b01, "R6 ch2 held while ch1 ramps", ch_on, 1);
    reg_ok = 2'b01;
    step(1);
    chk(ch_on[1] == 1'b0, "R6 ch2 not yet", ch_on[1], 0);
    step(1);
    chk(ch_on == 2'b11 && ch_start == 2'b10, "R6 ch2 starts after regulation", {ch_on, ch_start}, 14);
    ch_en = 2'b10;
    step(3);
    chk(ch_on == 2'b10, "R11 only ch1 off", ch_on, 2);
    chk(bgap_on && vref_on, "R11 shared stages kept", stages(), 6);
    ch_en = 2'b00;
    step(3);
    chk(stages() == 0 && ch_on == 2'b00, "R1 shutdown after both low", stages(), 0);
  endtask

  task automatic t_both_together();
    go_idle();
    ch_en = 2'b11;
    wait_any_on(20);
    chk(ch_on == 2'b01, "R5 ch1 first", ch_on, 1);
    step(5);
    chk(ch_on == 2'b01, "R5 ch2 waits", ch_on, 1);
    reg_ok = 2'b11;
    step(2);
    chk(ch_on == 2'b11, "R5 ch2 after ch1 regulated", ch_on, 3);
  endtask

  task automatic t_ch2_first_preempted();
    go_idle();
    ch_en = 2'b10;
    for (int k = 0; k < 10 && !trim_load; k++) step(1);
    chk(trim_load == 1'b1, "R7 sequence started", trim_load, 1);
    ch_en = 2'b11;
    wait_any_on(12);
    chk(ch_on == 2'b01, "R7 ch1 preempts ch2", ch_on, 1);
    reg_ok = 2'b01;
    step(3);
    chk(ch_on == 2'b11, "R7 ch2 follows", ch_on, 3);
  endtask

  task automatic t_parallel();
    go_idle();
    ch_en = 2'b10;
    wait_any_on(20);
    chk(ch_on == 2'b10, "R8 ch2 alone", ch_on, 2);
    step(2);
    ch_en = 2'b11;
    step(2);
    chk(ch_on == 2'b10, "R8 ch1 not before 3rd edge", ch_on, 2);
    step(1);
    chk(ch_on == 2'b11 && ch_start == 2'b01, "R8 ch1 starts at once", {ch_on, ch_start}, 13);
  endtask

  task automatic t_supply_gate();
    go_idle();
    sup_ok = 1'b0;
    ch_en  = 2'b01;
    step(20);
    chk(stages() == 0, "R3 held without supply", stages(), 0);
    sup_ok = 1'b1;
    for (int k = 0; k < 8 && !trim_load; k++) step(1);
    chk(trim_load == 1'b1, "R3 starts once supply good", trim_load, 1);
  endtask

  // Supply loss on the same cycle channel 2 would be released.
  task automatic t_supply_race();
    go_idle();
    ch_en = 2'b11;
    wait_any_on(20);
    step(2);
    chk(ch_on == 2'b01, "R9 setup ch2 waiting", ch_on, 1);
    sup_ok = 1'b0;
    step(1);
    reg_ok = 2'b01;
    step(1);
    chk(ch_on == 2'b01 && ch_start == 2'b00, "R9 before race edge", {ch_on, ch_start}, 4);
    step(1);
    chk(ch_start == 2'b00, "R9 no ch2 strobe on supply loss", ch_start, 0);
    chk(ch_on == 2'b00 && stages() == 0, "R9 all off", {ch_on, stages()[3:0]}, 0);
    step(5);
    chk(ch_on == 2'b00 && stages() == 0, "R9 stays off", ch_on, 0);
    sup_ok = 1'b1;
    wait_any_on(20);
    chk(ch_on == 2'b01, "R9 restart ch1 first", ch_on, 1);
    step(2);
    chk(ch_on == 2'b11, "R9 restart both", ch_on, 3);
  endtask

  task automatic t_timeout();
    go_idle();
    auto_rdy = 4'b1101;
    ch_en = 2'b01;
    for (int k = 0; k < 10 && !trim_load; k++) step(1);
    step(1);
    chk(bgap_on == 1'b1, "R10 waiting on bandgap", bgap_on, 1);
    step(30);
    chk(fault == 1'b0, "R10 no early fault", fault, 0);
    for (int k = 0; k < 60 && !fault; k++) step(1);
    chk(fault == 1'b1, "R10 fault raised", fault, 1);
    chk(stages() == 0 && ch_on == 2'b00, "R10 outputs dropped", stages(), 0);
    step(20);
    chk(fault == 1'b1 && stages() == 0, "R10 fault held, no restart", fault, 1);
    ch_en = 2'b00;
    step(3);
    chk(fault == 1'b0, "R10 fault cleared", fault, 0);
    auto_rdy = 4'hF;
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_both_together();
    t_ch2_first_preempted();
    t_parallel();
    t_supply_gate();
    t_supply_race();
    t_timeout();
    go_idle();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule